// File: doc/BRIEF.md
# Flagged Saturating Add/Subtract Unit

This unit adds two integer operands of either 16 or 32 bits and can also subtract in either direction or add with an externally supplied carry. Every result comes with four condition flags: carry, signed overflow, sign and zero. An optional mode clamps a signed overflow to the nearest representable extreme instead of letting the result wrap. The arithmetic is a single combinational path. A parameter places a one-entry output register behind it.

Operands enter on a valid/ready stream together with their control fields, and results leave on a second valid/ready stream. With the output register built (`REG_OUT=1`) the rules are as follows. A transfer on the input side happens on a clock edge where `in_valid` and `in_ready` are both high, and the result appears on the output one cycle later. `in_ready` is high when the output register is empty or when the consumer is taking its contents in the same cycle. While `out_valid` is high and `out_ready` is low, the result and flags hold and no new operands are accepted.

With `REG_OUT=0` both streams are wired straight through: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `addsat_unit`

## Requirements
- R1: `in_op` selects the operation. 00 adds a + b with carry-in 0. 01 adds a + ~b with carry-in 1 (a minus b). 10 adds ~a + b with carry-in 1 (b minus a). 11 adds a + b + `in_cin`.
- R2: `out_c` is the bit just above the operand width of the unbounded sum of the two adder inputs and the carry-in. That is bit 16 when `in_wide`=0 and bit 32 when `in_wide`=1.
- R3: `out_v` is 1 exactly when the two adder inputs, taken after any inversion, share a sign bit and the wrapped sum's sign bit differs from it. The sign bit is bit 15 when `in_wide`=0 and bit 31 when `in_wide`=1.
- R4: When `in_sat`=1 and overflow occurs, a wrapped result with its sign bit set becomes the largest positive value (0x7FFF or 0x7FFFFFFF). A wrapped result with its sign bit clear becomes the smallest negative value (0x8000 or 0x80000000). In every other case the wrapped result is delivered unchanged.
- R5: `out_n` equals the sign bit of the delivered result (bit 15 or bit 31), and `out_z` is 1 exactly when the delivered result is zero. Both are taken after saturation.
- R6: When `in_wide`=0, bits 31..16 of both operands have no effect, and bits 31..16 of `out_res` are zero.
- R7: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and `out_res` and the flags hold their values. When the output register is empty or `out_ready`=1, `in_ready` is 1.
- R8: During reset and after it, `out_valid` is 0 until an input transfer is accepted. An accepted transfer appears on the output in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands and controls are present |
| in_ready | output | 1 | Unit can accept operands |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand |
| in_op | input | 2 | Operation select (R1) |
| in_wide | input | 1 | 1: full width, 0: narrow width |
| in_sat | input | 1 | Enable signed saturation |
| in_cin | input | 1 | Carry input for add-with-carry |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | DATA_W | Result, zero-extended in narrow mode |
| out_c | output | 1 | Carry flag |
| out_v | output | 1 | Overflow flag |
| out_n | output | 1 | Sign flag |
| out_z | output | 1 | Zero flag |

## Verification
The bench builds the unit with its defaults: a 32-bit datapath, a 16-bit narrow mode and the registered output. Because `in_wide` selects the width on every transfer, both widths and their separate carry and overflow bit positions are covered in one build. The registered output stage also makes the stall path reachable: in_ready dropping and the result holding under back-pressure. The signed extremes, zero and all-ones are crossed with every operation, width and saturation setting, and random operands are compared against a wide-integer model.

// File: rtl/addsat_pkg.sv
package addsat_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_RSUB = 2'b10,
    OP_ADDC = 2'b11
  } addsat_op_e;

  typedef struct packed {
    logic c;
    logic v;
    logic n;
    logic z;
  } addsat_flags_t;

endpackage

// File: rtl/addsat_prep.sv
// Operand conditioning: width masking, per-operation inversion and carry-in.
module addsat_prep
  import addsat_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  addsat_op_e        op,
  input  logic              wide,
  input  logic              cin_ext,
  output logic [DATA_W-1:0] s1,
  output logic [DATA_W-1:0] s2,
  output logic              cin
);
  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] am;
  logic [DATA_W-1:0] bm;

  always_comb begin
    mask = wide ? {DATA_W{1'b1}} : {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};
    am   = a & mask;
    bm   = b & mask;
  end

  always_comb begin
    s1  = am;
    s2  = bm;
    cin = 1'b0;
    unique case (op)
      OP_ADD: begin
        cin = 1'b0;
      end
      OP_SUB: begin
        s2  = ~bm & mask;
        cin = 1'b1;
      end
      OP_RSUB: begin
        s1  = ~am & mask;
        cin = 1'b1;
      end
      OP_ADDC: begin
        cin = cin_ext;
      end
      default: begin
        cin = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/addsat_adder.sv
// One full-width adder serving both widths; carry and overflow picked by width.
module addsat_adder #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic [DATA_W-1:0] s1,
  input  logic [DATA_W-1:0] s2,
  input  logic              cin,
  input  logic              wide,
  output logic [DATA_W-1:0] wrapped,
  output logic              carry,
  output logic              ovf
);
  localparam int SUM_W = DATA_W + 1;
  localparam int PAD_W = DATA_W - NARROW_W;

  logic [SUM_W-1:0]  sum;
  logic [DATA_W-1:0] mask;
  logic              sg1;
  logic              sg2;
  logic              sgr;

  always_comb begin
    sum     = {1'b0, s1} + {1'b0, s2} + {{DATA_W{1'b0}}, cin};
    mask    = wide ? {DATA_W{1'b1}} : {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};
    wrapped = sum[DATA_W-1:0] & mask;
    carry   = wide ? sum[DATA_W] : sum[NARROW_W];
    sg1     = wide ? s1[DATA_W-1] : s1[NARROW_W-1];
    sg2     = wide ? s2[DATA_W-1] : s2[NARROW_W-1];
    sgr     = wide ? wrapped[DATA_W-1] : wrapped[NARROW_W-1];
    ovf     = (sg1 == sg2) && (sgr != sg1);
  end

endmodule

// File: rtl/addsat_clamp.sv
// Saturation on overflow and result-derived sign/zero flags.
module addsat_clamp #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic [DATA_W-1:0] wrapped,
  input  logic              ovf,
  input  logic              sat,
  input  logic              wide,
  output logic [DATA_W-1:0] res,
  output logic              neg,
  output logic              zero
);
  localparam int PAD_W = DATA_W - NARROW_W;
  localparam logic [DATA_W-1:0] WIDE_MAX   = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] WIDE_MIN   = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] NARROW_MAX = {{PAD_W{1'b0}}, 1'b0, {(NARROW_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NARROW_MIN = {{PAD_W{1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};

  logic wsign;

  always_comb begin
    wsign = wide ? wrapped[DATA_W-1] : wrapped[NARROW_W-1];
    res   = wrapped;
    if (sat && ovf) begin
      if (wsign) res = wide ? WIDE_MAX : NARROW_MAX;
      else       res = wide ? WIDE_MIN : NARROW_MIN;
    end
    neg  = wide ? res[DATA_W-1] : res[NARROW_W-1];
    zero = (res == '0);
  end

endmodule

// File: rtl/addsat_unit.sv
module addsat_unit
  import addsat_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        in_op,
  input  logic              in_wide,
  input  logic              in_sat,
  input  logic              in_cin,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_res,
  output logic              out_c,
  output logic              out_v,
  output logic              out_n,
  output logic              out_z
);
  logic [DATA_W-1:0] op_s1;
  logic [DATA_W-1:0] op_s2;
  logic              op_cin;
  logic [DATA_W-1:0] core_wrapped;
  logic              core_carry;
  logic              core_ovf;
  logic [DATA_W-1:0] comb_res;
  addsat_flags_t     comb_flags;
  logic              cl_neg;
  logic              cl_zero;

  addsat_prep #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_prep (
    .a       (in_a),
    .b       (in_b),
    .op      (addsat_op_e'(in_op)),
    .wide    (in_wide),
    .cin_ext (in_cin),
    .s1      (op_s1),
    .s2      (op_s2),
    .cin     (op_cin)
  );

  addsat_adder #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_adder (
    .s1      (op_s1),
    .s2      (op_s2),
    .cin     (op_cin),
    .wide    (in_wide),
    .wrapped (core_wrapped),
    .carry   (core_carry),
    .ovf     (core_ovf)
  );

  addsat_clamp #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_clamp (
    .wrapped (core_wrapped),
    .ovf     (core_ovf),
    .sat     (in_sat),
    .wide    (in_wide),
    .res     (comb_res),
    .neg     (cl_neg),
    .zero    (cl_zero)
  );

  always_comb begin
    comb_flags.c = core_carry;
    comb_flags.v = core_ovf;
    comb_flags.n = cl_neg;
    comb_flags.z = cl_zero;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic              full_q;
      logic [DATA_W-1:0] res_q;
      addsat_flags_t     flags_q;
      logic              take;

      assign in_ready = !full_q || out_ready;
      assign take     = in_valid && in_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          full_q <= 1'b0;
        end else if (take) begin
          full_q <= 1'b1;
        end else if (out_ready) begin
          full_q <= 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q   <= '0;
          flags_q <= '0;
        end else if (take) begin
          res_q   <= comb_res;
          flags_q <= comb_flags;
        end
      end

      assign out_valid = full_q;
      assign out_res   = res_q;
      assign out_c     = flags_q.c;
      assign out_v     = flags_q.v;
      assign out_n     = flags_q.n;
      assign out_z     = flags_q.z;
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_res   = comb_res;
      assign out_c     = comb_flags.c;
      assign out_v     = comb_flags.v;
      assign out_n     = comb_flags.n;
      assign out_z     = comb_flags.z;
    end
  endgenerate

endmodule

// File: rtl/addsat_unit_chk.sv
module addsat_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter bit REG_OUT  = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_res,
  input logic              out_c,
  input logic              out_v,
  input logic              out_n,
  input logic              out_z,
  input logic              comb_wide,
  input logic              comb_sat,
  input logic              comb_ovf,
  input logic [DATA_W-1:0] comb_res
);
  localparam int PAD_W = DATA_W - NARROW_W;
  localparam logic [DATA_W-1:0] WMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] WMIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] NMAX = {{PAD_W{1'b0}}, 1'b0, {(NARROW_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NMIN = {{PAD_W{1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};

  assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !comb_wide |-> (comb_res[DATA_W-1:NARROW_W] == '0));

  assert_sat_extreme_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_sat && comb_ovf) |->
      (comb_wide ? (comb_res == WMAX || comb_res == WMIN)
                 : (comb_res == NMAX || comb_res == NMIN)));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_z == (out_res == '0)));

  generate
    if (REG_OUT) begin : g_reg_chk
      assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
          (out_valid && $stable(out_res) && $stable(out_c) && $stable(out_v)
           && $stable(out_n) && $stable(out_z)));

      assert_stall_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

      assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

      assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !in_valid) |=> !out_valid);
    end
  endgenerate

endmodule

bind addsat_unit addsat_unit_chk #(
  .DATA_W(DATA_W), .NARROW_W(NARROW_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_res   (out_res),
  .out_c     (out_c),
  .out_v     (out_v),
  .out_n     (out_n),
  .out_z     (out_z),
  .comb_wide (in_wide),
  .comb_sat  (in_sat),
  .comb_ovf  (core_ovf),
  .comb_res  (comb_res)
);

// File: tb/test_addsat_unit.sv
`timescale 1ns/1ps
module test_addsat_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic [1:0]   in_op = 2'b00;
  logic         in_wide = 1'b1;
  logic         in_sat = 1'b0;
  logic         in_cin = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_res;
  logic         out_c, out_v, out_n, out_z;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  addsat_unit #(.DATA_W(W), .NARROW_W(16), .REG_OUT(1'b1)) i_addsat_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .in_wide(in_wide),
    .in_sat(in_sat), .in_cin(in_cin), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_c(out_c),
    .out_v(out_v), .out_n(out_n), .out_z(out_z)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        wide;
    logic        sat;
    logic        cin;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        c;
    logic        v;
    logic        n;
    logic        z;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b1, 1'b0, 1'b0, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'b00, 1'b1, 1'b0, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1, 1'b1, 1'b0},
    '{2'b00, 1'b1, 1'b1, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2'b01, 1'b1, 1'b0, 1'b0, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b1},
    '{2'b01, 1'b1, 1'b1, 1'b0, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1, 1'b1, 1'b1, 1'b0},
    '{2'b10, 1'b0, 1'b0, 1'b0, 32'h00000003, 32'h0000000A, 32'h00000007, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'b11, 1'b0, 1'b0, 1'b1, 32'h0000FFFF, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b1},
    '{2'b00, 1'b0, 1'b0, 1'b0, 32'hABCD7FFF, 32'h12340001, 32'h00008000, 1'b0, 1'b1, 1'b1, 1'b0},
    '{2'b00, 1'b0, 1'b1, 1'b0, 32'hABCD7FFF, 32'h12340001, 32'h00007FFF, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2'b11, 1'b1, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b1, 1'b0},
    '{2'b00, 1'b0, 1'b1, 1'b0, 32'h00008000, 32'h00008000, 32'h00008000, 1'b1, 1'b1, 1'b1, 1'b0},
    '{2'b01, 1'b0, 1'b0, 1'b0, 32'h00008000, 32'h00000001, 32'h00007FFF, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  // Wide-integer model written from the requirements.
  task automatic model(input logic [1:0] op, input logic wide, input logic sat,
                       input logic cin, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] res, output logic c, output logic v,
                       output logic n, output logic z);
    int          w  = wide ? 32 : 16;
    logic [63:0] mk = (64'd1 << w) - 64'd1;
    logic [63:0] x  = {32'd0, a} & mk;
    logic [63:0] y  = {32'd0, b} & mk;
    logic [63:0] ci = 64'd0;
    logic [63:0] full;
    logic [63:0] r;
    case (op)
      2'b01: begin y = ~y & mk; ci = 64'd1; end
      2'b10: begin x = ~x & mk; ci = 64'd1; end
      2'b11: ci = {63'd0, cin};
      default: ci = 64'd0;
    endcase
    full = x + y + ci;
    c    = full[w];
    r    = full & mk;
    v    = (x[w-1] == y[w-1]) && (r[w-1] != x[w-1]);
    if (sat && v) r = r[w-1] ? ((64'd1 << (w-1)) - 64'd1) : (64'd1 << (w-1));
    res = r[31:0];
    n   = r[w-1];
    z   = (r == 64'd0);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One transfer with out_ready high; result sampled at the following negedge.
  task automatic apply(input logic [1:0] op, input logic wide, input logic sat,
                       input logic cin, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_op = op; in_wide = wide; in_sat = sat; in_cin = cin;
    in_a = a; in_b = b; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic compare_all(input logic [1:0] op, input logic wide, input logic sat,
                             input logic cin, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic c, v, n, z;
    model(op, wide, sat, cin, a, b, r, c, v, n, z);
    apply(op, wide, sat, cin, a, b);
    chk("R8", "valid", {31'd0, out_valid}, 32'd1);
    chk(sat ? "R4" : (wide ? "R1" : "R6"), "res", out_res, r);
    chk("R2", "carry", {31'd0, out_c}, {31'd0, c});
    chk("R3", "ovf", {31'd0, out_v}, {31'd0, v});
    chk("R5", "sign", {31'd0, out_n}, {31'd0, n});
    chk("R5", "zero", {31'd0, out_z}, {31'd0, z});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] corners [7];
    logic [31:0] r;
    logic c, v, n, z;
    corners = '{32'h0, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000,
                32'h7FFF, 32'h8000, 32'hFFFF};

    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8", "valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R7", "ready when empty", {31'd0, in_ready}, 32'd1);

    // Vector table with hand-derived expectations.
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].wide, VECS[i].sat, VECS[i].cin, VECS[i].a, VECS[i].b);
      chk("R1", "table res", out_res, VECS[i].res);
      chk("R2", "table carry", {31'd0, out_c}, {31'd0, VECS[i].c});
      chk("R3", "table ovf", {31'd0, out_v}, {31'd0, VECS[i].v});
      chk("R5", "table sign", {31'd0, out_n}, {31'd0, VECS[i].n});
      chk("R5", "table zero", {31'd0, out_z}, {31'd0, VECS[i].z});
    end

    // R6: upper operand bits ignored in narrow mode
    apply(2'b01, 1'b0, 1'b0, 1'b0, 32'hFFFF1234, 32'h00001234);
    chk("R6", "narrow junk res", out_res, 32'h0);
    chk("R6", "narrow junk zero", {31'd0, out_z}, 32'd1);

    // Corner sweep against the model.
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 7; j++)
        for (int k = 0; k < 16; k++)
          compare_all(k[1:0], k[2], k[3], k[0] ^ k[1], corners[i], corners[j]);

    // Random operands.
    for (int i = 0; i < 400; i++)
      compare_all(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  $urandom, $urandom);

    // R7: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 2'b00; in_wide = 1'b1; in_sat = 1'b0; in_cin = 1'b0;
    in_a = 32'h00000010; in_b = 32'h00000020; in_valid = 1'b1;
    @(negedge clk);
    chk("R7", "held valid", {31'd0, out_valid}, 32'd1);
    chk("R7", "stall ready", {31'd0, in_ready}, 32'd0);
    in_a = 32'h00000100; in_b = 32'h00000200;
    @(negedge clk);
    chk("R7", "held res", out_res, 32'h00000030);
    chk("R7", "stall ready again", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    #1;
    chk("R7", "ready on drain", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", "next res", out_res, 32'h00000300);
    model(2'b00, 1'b1, 1'b0, 1'b0, 32'h100, 32'h200, r, c, v, n, z);
    chk("R5", "next zero", {31'd0, out_z}, {31'd0, z});
    @(negedge clk);
    chk("R8", "drained", {31'd0, out_valid}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule